// File: doc/BRIEF.md
# Serial Flash Auto Page Rewrite Engine

This block is the device side of a serial flash model. It decodes the command that rewrites one page of the main array in place. A host clocks in a one-byte opcode and a 24-bit address over an SPI mode 0 link made of SCK, an active-low chip select and a serial data input. The engine does nothing until chip select returns high. At that point, if a well-formed rewrite command was received, it runs a self-timed operation in two phases. First it loads the addressed page of its internal main array into a page buffer. Then it programs the buffer back into the same page.

The page number always has 10 bits, but its position in the address depends on the page-size configuration input. For the whole self-timed interval, `busy` is high. A strobe pulses once for every byte moved in either phase. The strobe carries the phase, the byte index, the page and the byte value, so an observer can confirm that the buffer received exactly what the page held and that the page got back exactly what the buffer held.

The array keeps all 1024 page numbers addressable. The physical storage holds `PAGE_SLOTS` pages, selected by the low bits of the page number, so the array stays small. SCK, chip select and data are sampled with the system clock, which must run at least four times faster than SCK.

Top module: `page_rewrite_engine`

## Requirements
- R1: While reset is applied, `busy` and `xfer_vld` are 0.
- R2: A command is opcode 0x58 followed by 24 address bits, all sent MSB first and sampled on rising SCK while `cs_n` is low. A valid command takes effect only when `cs_n` rises. `busy` goes high on the clock after that rise is sampled.
- R3: With `page_256`=0 (264-byte pages), the page number is address bits 18..9. Address bit 23 is the first bit after the opcode. The other 14 address bits are ignored.
- R4: With `page_256`=1 (256-byte pages), the page number is address bits 17..8. The other 14 address bits are ignored.
- R5: If the number of SCK rising edges during the select is not exactly 32, the command is discarded and `busy` stays 0.
- R6: An opcode other than 0x58 starts nothing.
- R7: A command whose `cs_n` rise arrives while `busy` is 1 is ignored. It does not start a second operation afterwards.
- R8: `busy` stays high for exactly `BUSY_CYCLES` clock cycles. `BUSY_CYCLES` must be larger than twice the page length.
- R9: After the start, `xfer_vld` pulses on consecutive clocks. There are L pulses with `xfer_phase`=0 (array to buffer), then L pulses with `xfer_phase`=1 (buffer to array). In each phase, `xfer_idx` runs from 0 to L-1. L is 264 or 256, set by `page_256` when the operation starts.
- R10: `xfer_data` is the array byte in phase 0 and the buffer byte in phase 1, so a rewrite leaves the page unchanged. The array starts with byte i of storage slot s equal to (29*s + 3*i + 1) mod 256. The slot is the page number modulo `PAGE_SLOTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| page_256 | input | 1 | 1 selects 256-byte pages, 0 selects 264-byte pages |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| busy | output | 1 | Self-timed rewrite in progress |
| xfer_vld | output | 1 | One pulse per byte moved |
| xfer_phase | output | 1 | 0 while loading the buffer, 1 while programming back |
| xfer_idx | output | 9 | Byte index within the page |
| xfer_page | output | 10 | Page number of the current or last operation |
| xfer_data | output | 8 | Byte moved |

## Verification
The assertions assume that SCK and `si` change only while `cs_n` is low, and that SCK is low when `cs_n` falls or rises. They also assume that each SCK level lasts several system clocks, so every edge is sampled once. The stimulus drives every input on falling system-clock edges, holds each SCK level for four clocks and keeps SCK low across every select transition. The only command that overlaps a busy interval is the one issued deliberately to check that commands are ignored while busy. Its select rise is timed well clear of the clock on which `busy` falls.

// File: rtl/page_rewrite_engine.sv
module page_rewrite_engine #(
  parameter int BUSY_CYCLES = 600,
  parameter int PAGE_SLOTS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       page_256,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       busy,
  output logic       xfer_vld,
  output logic       xfer_phase,
  output logic [8:0] xfer_idx,
  output logic [9:0] xfer_page,
  output logic [7:0] xfer_data
);
  localparam int MAXLEN = 264;
  localparam int SW = $clog2(PAGE_SLOTS);
  localparam int AW = $clog2(PAGE_SLOTS * MAXLEN);
  localparam int TW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, LOAD, STORE, HOLD} st_t;

  logic [7:0] mem  [PAGE_SLOTS*MAXLEN];
  logic [7:0] pbuf [MAXLEN];
  logic        sck_d, cs_d, mode_q;
  logic [31:0] sh;
  logic [5:0]  nbits;
  logic [8:0]  idx;
  logic [TW-1:0] tmr;
  st_t st;

  initial begin
    for (int s = 0; s < PAGE_SLOTS; s++)
      for (int i = 0; i < MAXLEN; i++)
        mem[s*MAXLEN+i] = 8'((29*s + 3*i + 1) % 256);
  end

  wire          sck_rise = sck & ~sck_d;
  wire          cs_rise  = cs_n & ~cs_d;
  wire          cmd_ok   = (nbits == 6'd32) && (sh[31:24] == 8'h58);
  wire          start    = cs_rise && cmd_ok && !busy;
  wire [8:0]    last     = mode_q ? 9'd255 : 9'd263;
  wire [SW-1:0] slot     = xfer_page[SW-1:0];
  wire [AW-1:0] addr     = AW'(slot) * AW'(MAXLEN) + AW'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
      sh    <= '0;
      nbits <= '0;
    end else begin
      sck_d <= sck;
      cs_d  <= cs_n;
      if (cs_n) nbits <= '0;
      else if (sck_rise) begin
        sh <= {sh[30:0], si};
        if (nbits != 6'd33) nbits <= nbits + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; busy <= 1'b0; idx <= '0; tmr <= '0; mode_q <= 1'b0;
      xfer_page <= '0; xfer_vld <= 1'b0; xfer_phase <= 1'b0;
      xfer_idx <= '0; xfer_data <= '0;
    end else begin
      xfer_vld <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        st        <= LOAD;
        idx       <= '0;
        tmr       <= '0;
        mode_q    <= page_256;
        xfer_page <= page_256 ? sh[17:8] : sh[18:9];
      end else if (busy) begin
        tmr <= tmr + TW'(1);
        if (tmr == TW'(BUSY_CYCLES - 1)) begin
          busy <= 1'b0;
          st   <= IDLE;
        end
        if (st == LOAD || st == STORE) begin
          xfer_vld   <= 1'b1;
          xfer_phase <= (st == STORE);
          xfer_idx   <= idx;
          xfer_data  <= (st == LOAD) ? mem[addr] : pbuf[idx];
          if (idx == last) begin
            idx <= '0;
            if (st == LOAD) st <= STORE;
            else st <= HOLD;
          end else idx <= idx + 9'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && st == LOAD)  pbuf[idx] <= mem[addr];
    if (busy && st == STORE) mem[addr] <= pbuf[idx];
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cmd_ok && !busy) |=> (busy && st == LOAD));
  p_short_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && nbits != 6'd32) |=> !busy);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_rise) |=> ($stable(xfer_page) && $stable(mode_q)));
  p_timer_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tmr == '0));
  p_vld_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> busy);
  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> (xfer_idx <= last));
endmodule

// File: tb/sim_page_rewrite_engine.sv
module sim_page_rewrite_engine;
  localparam int BUSY  = 600;
  localparam int SLOTS = 8;

  logic clk = 1'b0, rst_n = 1'b0, page_256 = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic busy, xfer_vld, xfer_phase;
  logic [8:0] xfer_idx;
  logic [9:0] xfer_page;
  logic [7:0] xfer_data;

  always #4 clk = ~clk;

  page_rewrite_engine #(.BUSY_CYCLES(BUSY), .PAGE_SLOTS(SLOTS)) u0 (
    .clk(clk), .rst_n(rst_n), .page_256(page_256), .sck(sck), .cs_n(cs_n), .si(si),
    .busy(busy), .xfer_vld(xfer_vld), .xfer_phase(xfer_phase), .xfer_idx(xfer_idx),
    .xfer_page(xfer_page), .xfer_data(xfer_data));

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_mem [SLOTS*264];
  int m_left, m_k, m_len, m_bits, m_slot;
  logic [9:0] m_page;
  logic [31:0] m_word;
  logic psck, pcs, e_vld, e_phase;
  int e_idx, e_data;
  bit was_busy;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  initial begin
    for (int s = 0; s < SLOTS; s++)
      for (int i = 0; i < 264; i++)
        m_mem[s*264+i] = 8'((29*s + 3*i + 1) % 256);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_k = 0; m_len = 264; m_bits = 0; m_slot = 0; m_page = '0;
      m_word = '0; psck = 1'b0; pcs = 1'b1; e_vld = 1'b0; e_phase = 1'b0;
      e_idx = 0; e_data = 0;
    end else begin
      e_vld = 1'b0;
      was_busy = (m_left > 0);
      if (m_left > 0) begin
        if (m_k < 2*m_len) begin
          e_vld = 1'b1;
          e_phase = (m_k >= m_len);
          e_idx = m_k % m_len;
          e_data = int'(m_mem[m_slot*264+e_idx]);
          m_k++;
        end
        m_left--;
      end
      if (!cs_n && sck && !psck) begin
        m_word = {m_word[30:0], si};
        m_bits++;
      end
      // R2: decision on the select rising edge
      if (cs_n && !pcs && m_bits == 32 && m_word[31:24] == 8'h58 && !was_busy) begin
        m_left = BUSY; m_k = 0;
        m_len  = page_256 ? 256 : 264;
        m_page = page_256 ? m_word[17:8] : m_word[18:9];
        m_slot = int'(m_page) % SLOTS;
      end
      if (cs_n) m_bits = 0;
      psck = sck; pcs = cs_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy === (m_left > 0), "R8", int'(busy), int'(m_left > 0));
      chk(xfer_vld === e_vld, "R9", int'(xfer_vld), int'(e_vld));
      if (e_vld && xfer_vld) begin
        chk(xfer_phase === e_phase, "R9", int'(xfer_phase), int'(e_phase));
        chk(int'(xfer_idx) == e_idx, "R9", int'(xfer_idx), e_idx);
        chk(xfer_page === m_page, m_len == 256 ? "R4" : "R3", int'(xfer_page), int'(m_page));
        chk(int'(xfer_data) == e_data, "R10", int'(xfer_data), e_data);
      end
    end
  end

  task automatic send(logic [7:0] op, logic [23:0] ad, int nb, bit mode);
    logic [31:0] w;
    w = {op, ad};
    @(negedge clk); page_256 = mode; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      si = (i < 32) ? w[31-i] : 1'b0;
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_left > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [23:0] a264(logic [9:0] p);
    return {5'h1F, p, 9'h1FF};
  endfunction
  function automatic logic [23:0] a256(logic [9:0] p);
    return {6'h3F, p, 8'hFF};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", int'(busy), 0);
    chk(xfer_vld === 1'b0, "R1", int'(xfer_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(8'h58, a264(10'h005), 32, 1'b0);       // R3
    chk(busy === 1'b1, "R2", int'(busy), 1);
    wait_idle();
    send(8'h58, a256(10'h3AB), 32, 1'b1);       // R4
    wait_idle();
    send(8'h58, a264(10'h2C6), 31, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R5", int'(busy), 0);
    send(8'h58, a264(10'h2C6), 33, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R5", int'(busy), 0);
    send(8'h59, a264(10'h001), 32, 1'b0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R6", int'(busy), 0);
    send(8'h58, a264(10'h002), 32, 1'b0);
    send(8'h58, a256(10'h007), 32, 1'b1);       // arrives while busy
    wait_idle();
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R7", int'(busy), 0);
    chk(xfer_page === 10'h002, "R7", int'(xfer_page), 2);
    send(8'h58, a256(10'h3AB), 32, 1'b1);       // R10 page unchanged after rewrite
    wait_idle();
    send(8'h58, a264(10'h3FF), 32, 1'b0);
    wait_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule